// File: doc/BRIEF.md
# Global Rate Tick and Noise Source

This block holds a single wrapping down-counter shared by every consumer that needs a slow, rate-selectable tick. The counter moves one step each time the sample strobe is high, so it advances once per output sample period. A 5-bit rate code picks one of 32 tick spacings. On each strobe the block decides whether the new counter value lands on a tick for the chosen rate. It latches that decision as a flag that stays valid until the next strobe.

The same tick clocks a 15-bit pseudo-random noise register. The noise value moves only in periods where the selected rate ticks, so the rate code also sets the noise pitch. Consumers read the tick flag and the noise word directly. The tick test is a modulo match against a per-rate spacing plus a per-rate phase shift, computed without a divider. Each spacing is factored into a power of two times 1, 3 or 5. The power-of-two part is checked by masking low bits, and the odd factor is checked with a mod-15 residue obtained by folding hex digits.

Top module: `glob_rate_noise`

## Requirements
- R1: While reset is held, and after it is released, tick reads 0 and noise reads 0x4000. The counter starts at 0, so with rate 31 the first strobe after reset ticks and noise becomes 0x2000.
- R2: On each strobe the counter becomes 0x77FF if it was 0 and otherwise drops by one.
- R3: On a strobe, tick is set when (C + ofs) mod per equals 0. C is the counter value after that strobe's update. For codes 1 to 29, write i = code-1, g = i/3 and j = i mod 3. Then per is 2^(11-g) with ofs 0 when j=0, 3*2^(9-g) with ofs 1040 when j=1, and 5*2^(8-g) with ofs 536 when j=2.
- R4: Rate code 0 (spacing 65535, shift 1) never produces a tick.
- R5: Rate code 30 ticks when C is even, and rate code 31 ticks on every strobe. Both use a shift of 0.
- R6: When tick is set, noise N becomes N>>1 with bit 14 taken from bit 0 XOR bit 1 of the old N. Noise is never zero.
- R7: On a strobe whose tick is clear, noise keeps its value.
- R8: Without a strobe the counter, tick and noise all hold, whatever the rate code does.
- R9: Tick is a registered flag. It shows the result one clock after the strobe cycle and holds it until the next strobe.
- R10: Asserting reset at any time clears tick and returns noise to 0x4000 at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a two-stage synchronizer |
| smp_strobe | input | 1 | One-cycle pulse per sample period; advances the counter |
| rate_sel | input | 5 | Tick rate code, sampled with the strobe |
| tick | output | 1 | Tick decision for the most recent strobe |
| noise | output | 15 | Current noise register value |

## Verification
Tick, noise and counter all register on the clock edge that samples a high strobe. Their new values are therefore due one cycle later, and the bench samples them at the falling edge that follows that edge. The bench also drops the strobe at that point, so every strobe is exactly one cycle long. Releasing reset takes two clocks through the synchronizer, so checks after a release wait three cycles. Asserting reset acts on the outputs at once, and the bench samples them a nanosecond later. The counter cannot be seen at the ports, so it is checked through a sweep longer than one full counter wrap. Every tick in that sweep is compared against a model that uses a true modulo.

// File: rtl/grn_pkg.sv
`timescale 1ns/1ps
package grn_pkg;

  localparam int RATE_W    = 5;
  localparam int NUM_RATES = 1 << RATE_W;
  localparam int OFS_W     = 11;
  localparam int SHF_W     = 4;

  // odd factor of a tick spacing
  typedef enum logic [1:0] {
    MUL_ONE   = 2'd0,
    MUL_THREE = 2'd1,
    MUL_FIVE  = 2'd2
  } mul_e;

  typedef struct packed {
    logic             never;
    mul_e             mul;
    logic [SHF_W-1:0] shift;
    logic [OFS_W-1:0] offset;
  } rate_rule_t;

  // spacing = mul * 2^shift, phase shift = offset
  function automatic rate_rule_t rule_of(int r);
    rate_rule_t rr;
    int i;
    int g;
    int j;
    rr.never  = 1'b0;
    rr.mul    = MUL_ONE;
    rr.shift  = '0;
    rr.offset = '0;
    if (r == 0) begin
      rr.never = 1'b1;
    end else if (r == NUM_RATES - 2) begin
      rr.shift = SHF_W'(1);
    end else if (r < NUM_RATES - 2) begin
      i = r - 1;
      g = i / 3;
      j = i % 3;
      case (j)
        0: begin
          rr.shift = SHF_W'(11 - g);
        end
        1: begin
          rr.mul    = MUL_THREE;
          rr.shift  = SHF_W'(9 - g);
          rr.offset = OFS_W'(1040);
        end
        default: begin
          rr.mul    = MUL_FIVE;
          rr.shift  = SHF_W'(8 - g);
          rr.offset = OFS_W'(536);
        end
      endcase
    end
    return rr;
  endfunction

endpackage

// File: rtl/grn_rate_decode.sv
`timescale 1ns/1ps
module grn_rate_decode
  import grn_pkg::*;
(
  input  logic [RATE_W-1:0] rate_i,
  output rate_rule_t        rule_o
);

  rate_rule_t tbl [NUM_RATES];

  for (genvar r = 0; r < NUM_RATES; r++) begin : g_tbl
    assign tbl[r] = rule_of(r);
  end

  assign rule_o = tbl[rate_i];

endmodule

// File: rtl/grn_rate_match.sv
`timescale 1ns/1ps
module grn_rate_match
  import grn_pkg::*;
#(
  parameter int CNT_W = 15
) (
  input  logic [CNT_W-1:0] cnt_i,
  input  rate_rule_t       rule_i,
  output logic             hit_o
);

  localparam int SUM_W = ((CNT_W > OFS_W) ? CNT_W : OFS_W) + 1;
  localparam int NIB   = (SUM_W + 3) / 4;
  localparam int PAD_W = NIB * 4;

  logic [PAD_W-1:0] sum;
  logic [PAD_W-1:0] mask;
  logic [PAD_W-1:0] quo;
  logic [7:0]       part [NIB+1];
  logic [7:0]       fold;
  logic [3:0]       res15;
  logic             low_ok;
  logic             mul_ok;

  assign sum    = PAD_W'(cnt_i) + PAD_W'(rule_i.offset);
  assign mask   = (PAD_W'(1) << rule_i.shift) - PAD_W'(1);
  assign quo    = sum >> rule_i.shift;
  assign low_ok = ((sum & mask) == '0);

  // 16 = 1 mod 15: digit sum keeps the residue
  assign part[0] = '0;
  for (genvar n = 0; n < NIB; n++) begin : g_nib
    assign part[n+1] = part[n] + 8'(quo[4*n +: 4]);
  end

  always_comb begin
    fold  = part[NIB];
    fold  = 8'(fold[7:4]) + 8'(fold[3:0]);
    fold  = 8'(fold[7:4]) + 8'(fold[3:0]);
    res15 = (fold[3:0] == 4'd15) ? 4'd0 : fold[3:0];
  end

  always_comb begin
    case (rule_i.mul)
      MUL_THREE: mul_ok = (res15 == 4'd0) || (res15 == 4'd3) || (res15 == 4'd6) ||
                          (res15 == 4'd9) || (res15 == 4'd12);
      MUL_FIVE:  mul_ok = (res15 == 4'd0) || (res15 == 4'd5) || (res15 == 4'd10);
      default:   mul_ok = 1'b1;
    endcase
  end

  assign hit_o = !rule_i.never && low_ok && mul_ok;

endmodule

// File: rtl/grn_noise_lfsr.sv
`timescale 1ns/1ps
module grn_noise_lfsr #(
  parameter int           W    = 15,
  parameter logic [W-1:0] SEED = 15'h4000
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv_i,
  output logic [W-1:0] state_o
);

  logic [W-1:0] st_q;
  logic [W-1:0] st_d;

  always_comb begin
    st_d = {st_q[0] ^ st_q[1], st_q[W-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= SEED;
    end else if (adv_i) begin
      st_q <= st_d;
    end
  end

  assign state_o = st_q;

endmodule

// File: rtl/glob_rate_noise.sv
`timescale 1ns/1ps
module glob_rate_noise
  import grn_pkg::*;
#(
  parameter int               CNT_W      = 15,
  parameter logic [CNT_W-1:0] CNT_RELOAD = 15'h77FF,
  parameter int               NOISE_W    = 15,
  parameter logic [NOISE_W-1:0] NOISE_SEED = 15'h4000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               smp_strobe,
  input  logic [RATE_W-1:0]  rate_sel,
  output logic               tick,
  output logic [NOISE_W-1:0] noise
);

  // reset: asserts at once, releases after two clocks
  logic [1:0] rs_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_q <= 2'b00;
    end else begin
      rs_q <= {rs_q[0], 1'b1};
    end
  end

  assign rst_sync_n = rs_q[1];

  // wrapping down-counter
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    if (cnt_q == '0) begin
      cnt_d = CNT_RELOAD;
    end else begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      cnt_q <= '0;
    end else if (smp_strobe) begin
      cnt_q <= cnt_d;
    end
  end

  // tick decision against the updated count
  rate_rule_t rule;
  logic       hit;

  grn_rate_decode u_dec (
    .rate_i (rate_sel),
    .rule_o (rule)
  );

  grn_rate_match #(.CNT_W(CNT_W)) u_match (
    .cnt_i  (cnt_d),
    .rule_i (rule),
    .hit_o  (hit)
  );

  logic tick_q;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      tick_q <= 1'b0;
    end else if (smp_strobe) begin
      tick_q <= hit;
    end
  end

  assign tick = tick_q;

  grn_noise_lfsr #(.W(NOISE_W), .SEED(NOISE_SEED)) u_lfsr (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .adv_i   (smp_strobe & hit),
    .state_o (noise)
  );

endmodule

// File: rtl/grn_checker.sv
`timescale 1ns/1ps
module grn_checker #(
  parameter int                 CNT_W      = 15,
  parameter logic [CNT_W-1:0]   CNT_RELOAD = 15'h77FF,
  parameter int                 NOISE_W    = 15,
  parameter logic [NOISE_W-1:0] NOISE_SEED = 15'h4000
) (
  input logic               clk,
  input logic               rst_n,
  input logic               strobe,
  input logic [4:0]         rate,
  input logic [CNT_W-1:0]   cnt,
  input logic               tick,
  input logic [NOISE_W-1:0] noise
);

  p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(strobe) |-> (cnt == (($past(cnt) == '0) ? CNT_RELOAD : $past(cnt) - 1'b1)));

  p_rate0_silent_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(strobe) && $past(rate) == 5'd0) |-> !tick);

  p_rate31_always_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(strobe) && $past(rate) == 5'd31) |-> tick);

  p_noise_shift_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(strobe) && tick) |->
      (noise[NOISE_W-2:0] == $past(noise[NOISE_W-1:1]) &&
       noise[NOISE_W-1] == ($past(noise[0]) ^ $past(noise[1]))));

  p_noise_nonzero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    noise != '0);

  p_noise_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(strobe) && !tick) |-> $stable(noise));

  p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(strobe) |-> ($stable(cnt) && $stable(tick) && $stable(noise)));

endmodule

bind glob_rate_noise grn_checker #(
  .CNT_W      (CNT_W),
  .CNT_RELOAD (CNT_RELOAD),
  .NOISE_W    (NOISE_W),
  .NOISE_SEED (NOISE_SEED)
) u_chk (
  .clk    (clk),
  .rst_n  (rst_sync_n),
  .strobe (smp_strobe),
  .rate   (rate_sel),
  .cnt    (cnt_q),
  .tick   (tick),
  .noise  (noise)
);

// File: tb/tb_glob_rate_noise.sv
`timescale 1ns/1ps
module tb_glob_rate_noise;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        strobe;
  logic [4:0]  rate;
  logic        tick;
  logic [14:0] noise;

  int checks = 0;
  int errors = 0;

  int          m_cnt;
  logic [14:0] m_noise;
  logic        m_tick;

  localparam int PER [32] = '{65535, 2048, 1536, 1280, 1024, 768, 640, 512,
                              384, 320, 256, 192, 160, 128, 96, 80,
                              64, 48, 40, 32, 24, 20, 16, 12,
                              10, 8, 6, 5, 4, 3, 2, 1};
  localparam int OFS [32] = '{1, 0, 1040, 536, 0, 1040, 536, 0,
                              1040, 536, 0, 1040, 536, 0, 1040, 536,
                              0, 1040, 536, 0, 1040, 536, 0, 1040,
                              536, 0, 1040, 536, 0, 1040, 0, 0};

  // {rate, strobe count}
  localparam logic [12:0] VEC [8] = '{
    {5'd31, 8'd6}, {5'd30, 8'd6}, {5'd29, 8'd10}, {5'd0, 8'd8},
    {5'd28, 8'd12}, {5'd27, 8'd12}, {5'd1, 8'd5}, {5'd13, 8'd20}
  };

  always #2 clk = ~clk;

  glob_rate_noise dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .smp_strobe (strobe),
    .rate_sel   (rate),
    .tick       (tick),
    .noise      (noise)
  );

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_cnt   = 0;
    m_noise = 15'h4000;
    m_tick  = 1'b0;
  endtask

  task automatic model_step(input logic [4:0] r);
    m_cnt  = (m_cnt == 0) ? 32'h77FF : m_cnt - 1;
    m_tick = (((m_cnt + OFS[r]) % PER[r]) == 0);
    if (m_tick) m_noise = {m_noise[0] ^ m_noise[1], m_noise[14:1]};
  endtask

  // one-cycle strobe; results due at the following falling edge
  task automatic strobe_chk(input logic [4:0] r);
    string ttag;
    @(negedge clk);
    strobe = 1'b1;
    rate   = r;
    model_step(r);
    @(negedge clk);
    strobe = 1'b0;
    ttag = (r == 5'd0) ? "R4" : ((r >= 5'd30) ? "R5" : "R3");
    check(ttag, "tick", 32'(tick), 32'(m_tick));
    check(m_tick ? "R6" : "R7", "noise", 32'(noise), 32'(m_noise));
  endtask

  initial begin
    rst_n  = 1'b0;
    strobe = 1'b0;
    rate   = 5'd0;
    model_reset();
    repeat (3) @(negedge clk);
    check("R1", "tick in reset", 32'(tick), 32'd0);
    check("R1", "noise in reset", 32'(noise), 32'h4000);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", "tick after release", 32'(tick), 32'd0);
    check("R1", "noise after release", 32'(noise), 32'h4000);

    // counter starts at 0 -> reload; rate 31 ticks at once
    strobe_chk(5'd31);
    check("R1", "first noise step", 32'(noise), 32'h2000);

    // R9 / R8: flag and noise hold while idle, rate wiggling
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      rate = 5'(k * 5);
    end
    check("R9", "tick held", 32'(tick), 32'd1);
    check("R8", "noise held", 32'(noise), 32'(m_noise));

    // table walk; the first strobe also shows R2/R8: no counter drift while idle
    for (int v = 0; v < 8; v++) begin
      for (int k = 0; k < int'(VEC[v][7:0]); k++) begin
        strobe_chk(VEC[v][12:8]);
      end
    end

    // R2 / R3: sweep past a full counter wrap, rotating through every rate
    for (int k = 0; k < 30800; k++) begin
      strobe_chk(5'((k * 13 + 7) % 32));
    end

    // R10: asynchronous reset mid-run
    strobe_chk(5'd31);
    @(negedge clk);
    #1 rst_n = 1'b0;
    #1;
    check("R10", "tick on async reset", 32'(tick), 32'd0);
    check("R10", "noise on async reset", 32'(noise), 32'h4000);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    model_reset();
    repeat (3) @(negedge clk);
    // rate 30: counter 0x77FF odd -> no tick, then 0x77FE -> tick
    strobe_chk(5'd30);
    check("R5", "rate30 odd count", 32'(tick), 32'd0);
    strobe_chk(5'd30);
    check("R5", "rate30 even count", 32'(tick), 32'd1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule